// File: doc/BRIEF.md
# Address Break Comparator Unit

This block is a debug breakpoint watcher for a 16-bit CPU bus. On every bus cycle it looks at the cycle type, the address and the data, and compares them with a programmed break address and break data. When the programmed condition is met, it sets a sticky break flag and raises an interrupt request. The flag stays set until software clears it.

Software programs the block through a small register port. There are four registers: an 8-bit control register, a break address register, a break data register and a status register. The control register chooses four things: which cycle type may match, how many upper address bits take part in the compare, which data byte lanes take part, and whether the request is held back for one instruction after a return from exception. The CPU reports completed instructions and completed returns from exception on two pulse inputs, and these drive that holdback.

Top module: `brk_watch`

## Requirements
- R1: After synchronous reset, the control register reads 0x0080, the address and data registers read 0x0000, the status register reads 0x0000, and `brk_irq` is low.
- R2: A write with `reg_sel` 0 loads control bits [7:0], 1 loads the break address, and 2 loads the break data. Each value reads back unchanged at the same `reg_sel` in the cycle after the write. Read data shows the selected register zero-extended; status bit 0 is the break flag.
- R3: The cycle-type field is control bits [6:5]. The value 00 matches only cycles with `bus_fetch`, 01 only `bus_read`, 10 only `bus_write`, and 11 either `bus_read` or `bus_write`. No cycle matches while `bus_valid` is low.
- R4: The address-mask field is control bits [4:2]. The value 000 compares all 16 address bits, 001 the upper 12, 010 the upper 8 and 011 the upper 4. A difference only in the ignored low bits still matches.
- R5: An address-mask field of 1xx (bit 4 set) never produces a match, even when the address is identical.
- R6: The data-compare field is control bits [1:0]. The value 00 ignores the data, 01 requires `bus_data[7:0]` to equal the low byte of the break data, 10 requires `bus_data[15:8]` to equal the high byte, and 11 requires all 16 bits to be equal. Data is compared only on read or write cycles; fetch cycles ignore it.
- R7: A match sets the break flag in the next cycle. The flag then stays set. Writing `reg_sel` 3 with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R8: With control bit 7 = 0, a `rte_done` pulse forces `brk_irq` low from the next cycle. The flag itself is kept. The request comes back in the cycle after the next `insn_done` pulse that comes without `rte_done`.
- R9: With control bit 7 = 1, `rte_done` has no effect, and `brk_irq` follows the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_fetch | input | 1 | Cycle is an instruction fetch/execute |
| bus_read | input | 1 | Cycle is a CPU data read |
| bus_write | input | 1 | Cycle is a CPU data write |
| bus_addr | input | 16 | Internal address bus |
| bus_data | input | 16 | Internal data bus |
| rte_done | input | 1 | Pulse: a return from exception completed |
| insn_done | input | 1 | Pulse: an instruction completed |
| brk_irq | output | 1 | Break interrupt request |

## Verification
The assertions assume that at most one of `bus_fetch`, `bus_read` and `bus_write` is high in any cycle. They also assume that the control register is never rewritten in the same cycle as a `rte_done` pulse; the holdback check relies on this. The stimulus meets both assumptions. Directed cycles pick exactly one type or none. The random phase draws a single type code per cycle and suppresses control writes whenever it raises `rte_done`. Random addresses and data are produced by flipping one nibble or byte of the programmed values, so near-misses and hits both occur often.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_RD    = 2'b01,
        CYC_WR    = 2'b10,
        CYC_RW    = 2'b11
    } cyc_sel_e;

    typedef enum logic [1:0] {
        DC_OFF = 2'b00,
        DC_LO  = 2'b01,
        DC_HI  = 2'b10,
        DC_ALL = 2'b11
    } dcmp_e;

    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_ADDR = 2'd1,
        RS_DATA = 2'd2,
        RS_STAT = 2'd3
    } reg_sel_e;

    // control byte: [7] holdback disable, [6:5] cycle type, [4:2] address mask, [1:0] data lanes
    typedef struct packed {
        logic     rte_irq_en;
        cyc_sel_e cyc;
        logic [2:0] amask;
        dcmp_e    dcmp;
    } brk_ctrl_t;

    localparam brk_ctrl_t CTRL_RST = '{
        rte_irq_en: 1'b1,
        cyc:        CYC_FETCH,
        amask:      3'b000,
        dcmp:       DC_OFF
    };

    function automatic logic amask_reserved(input logic [2:0] am);
        return am[2];
    endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input  brk_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0]  bar,
    input  logic [DATA_W-1:0]  bdr,
    input  logic               bus_valid,
    input  logic               bus_fetch,
    input  logic               bus_read,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               hit
);

    localparam int unsigned NIBS  = ADDR_W / NIB_W;
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [NIBS-1:0]  nib_eq;
    logic [NIBS-1:0]  nib_skip;
    logic [LANES-1:0] lane_eq;
    logic             cyc_ok;
    logic             addr_ok;
    logic             data_ok;
    logic             data_cyc;

    // per-nibble equality; low nibbles are skipped according to the mask level
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nib_eq[g]   = (bus_addr[g*NIB_W +: NIB_W] == bar[g*NIB_W +: NIB_W]);
        assign nib_skip[g] = (int'(ctrl.amask[1:0]) > g);
    end

    // per-lane data equality
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_eq[l] = (bus_data[l*LANE_W +: LANE_W] == bdr[l*LANE_W +: LANE_W]);
    end

    always_comb begin
        case (ctrl.cyc)
            CYC_FETCH: cyc_ok = bus_fetch;
            CYC_RD:    cyc_ok = bus_read;
            CYC_WR:    cyc_ok = bus_write;
            default:   cyc_ok = bus_read | bus_write;
        endcase
    end

    assign addr_ok  = !amask_reserved(ctrl.amask) && (&(nib_eq | nib_skip));
    assign data_cyc = bus_read | bus_write;

    always_comb begin
        if (!data_cyc) begin
            data_ok = 1'b1;
        end else begin
            case (ctrl.dcmp)
                DC_OFF:  data_ok = 1'b1;
                DC_LO:   data_ok = lane_eq[0];
                DC_HI:   data_ok = lane_eq[LANES-1];
                default: data_ok = &lane_eq;
            endcase
        end
    end

    assign hit = bus_valid & cyc_ok & addr_ok & data_ok;

endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PORT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [1:0]         sel,
    input  logic [PORT_W-1:0]  wdata,
    input  logic               flag,
    output logic [PORT_W-1:0]  rdata,
    output brk_ctrl_t          ctrl_q,
    output logic [ADDR_W-1:0]  bar_q,
    output logic [DATA_W-1:0]  bdr_q,
    output logic               stat_clr
);

    localparam int unsigned CTRL_W = $bits(brk_ctrl_t);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            bar_q  <= '0;
            bdr_q  <= '0;
        end else if (wr) begin
            case (sel_e)
                RS_CTRL: ctrl_q <= brk_ctrl_t'(wdata[CTRL_W-1:0]);
                RS_ADDR: bar_q  <= wdata[ADDR_W-1:0];
                RS_DATA: bdr_q  <= wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // only a zero written to status bit 0 clears the flag
    assign stat_clr = wr && (sel_e == RS_STAT) && !wdata[0];

    always_comb begin
        rdata = '0;
        case (sel_e)
            RS_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
            RS_ADDR: rdata[ADDR_W-1:0] = bar_q;
            RS_DATA: rdata[DATA_W-1:0] = bdr_q;
            default: rdata[0]          = flag;
        endcase
    end

endmodule

// File: rtl/brk_irq_ctl.sv
module brk_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic stat_clr,
    input  logic rte_done,
    input  logic insn_done,
    input  logic rte_en,
    output logic flag_q,
    output logic irq
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            // a new match outranks a clear in the same cycle
            if (hit) begin
                flag_q <= 1'b1;
            end else if (stat_clr) begin
                flag_q <= 1'b0;
            end
            if (rte_done) begin
                hold_q <= !rte_en;
            end else if (insn_done) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign irq = flag_q & ~(hold_q & ~rte_en);

endmodule

// File: rtl/brk_watch.sv
module brk_watch
    import brk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned PORT_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [PORT_W-1:0]  reg_wdata,
    output logic [PORT_W-1:0]  reg_rdata,
    input  logic               bus_valid,
    input  logic               bus_fetch,
    input  logic               bus_read,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               rte_done,
    input  logic               insn_done,
    output logic               brk_irq
);

    brk_ctrl_t         ctrl_q;
    logic [ADDR_W-1:0] bar_q;
    logic [DATA_W-1:0] bdr_q;
    logic              stat_clr;
    logic              hit;
    logic              flag_q;

    brk_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .flag     (flag_q),
        .rdata    (reg_rdata),
        .ctrl_q   (ctrl_q),
        .bar_q    (bar_q),
        .bdr_q    (bdr_q),
        .stat_clr (stat_clr)
    );

    brk_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) match_i (
        .ctrl      (ctrl_q),
        .bar       (bar_q),
        .bdr       (bdr_q),
        .bus_valid (bus_valid),
        .bus_fetch (bus_fetch),
        .bus_read  (bus_read),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .hit       (hit)
    );

    brk_irq_ctl irq_i (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .stat_clr  (stat_clr),
        .rte_done  (rte_done),
        .insn_done (insn_done),
        .rte_en    (ctrl_q.rte_irq_en),
        .flag_q    (flag_q),
        .irq       (brk_irq)
    );

endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [15:0]       reg_wdata,
    input logic              bus_valid,
    input logic              bus_fetch,
    input logic              bus_read,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_data,
    input logic              rte_done,
    input logic              brk_irq,
    input logic              flag_q,
    input logic [7:0]        ctrl_b,
    input logic [DATA_W-1:0] bdr_b
);

    // R3
    cyc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_fetch, bus_read, bus_write}));

    // R3
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(bus_valid));

    // R5
    reserved_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_b[4] && !flag_q) |=> !flag_q);

    // R6
    full_data_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_read && ctrl_b[6:5] == 2'b01 && ctrl_b[1:0] == 2'b11
         && bus_data != bdr_b && !flag_q) |=> !flag_q);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(reg_wr && reg_sel == 2'd3 && !reg_wdata[0])) |=> flag_q);

    // R8
    rte_holdback_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_b[7] && rte_done && !(reg_wr && reg_sel == 2'd0)) |=> !brk_irq);

endmodule

bind brk_watch brk_watch_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata[15:0]),
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .bus_read  (bus_read),
    .bus_write (bus_write),
    .bus_data  (bus_data),
    .rte_done  (rte_done),
    .brk_irq   (brk_irq),
    .flag_q    (flag_q),
    .ctrl_b    (ctrl_q),
    .bdr_b     (bdr_q)
);

// File: tb/brk_watch_tb.sv
`timescale 1ns/1ps
module brk_watch_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        bus_valid, bus_fetch, bus_read, bus_write;
    logic [15:0] bus_addr, bus_data;
    logic        rte_done, insn_done;
    logic        brk_irq;

    always #2 clk = ~clk;

    brk_watch dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_read(bus_read),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_data(bus_data),
        .rte_done(rte_done), .insn_done(insn_done), .brk_irq(brk_irq)
    );

    // behavioural reference state
    bit [7:0]  m_ctrl;
    bit [15:0] m_bar, m_bdr;
    bit        m_flag, m_hold;
    int        n_chk = 0;
    int        n_fail = 0;
    string     cur_req = "R1";
    bit        finished = 0;

    task automatic expect_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_hit();
        bit t_ok, a_ok, d_ok;
        int sh;
        if (!bus_valid) return 0;
        case (m_ctrl[6:5])
            2'd0: t_ok = bus_fetch;
            2'd1: t_ok = bus_read;
            2'd2: t_ok = bus_write;
            default: t_ok = bus_read || bus_write;
        endcase
        if (m_ctrl[4]) return 0;
        sh = 4 * int'(m_ctrl[3:2]);
        a_ok = ((bus_addr >> sh) == (m_bar >> sh));
        if (!(bus_read || bus_write)) d_ok = 1;
        else case (m_ctrl[1:0])
            2'd0: d_ok = 1;
            2'd1: d_ok = (bus_data[7:0] == m_bdr[7:0]);
            2'd2: d_ok = (bus_data[15:8] == m_bdr[15:8]);
            default: d_ok = (bus_data == m_bdr);
        endcase
        return t_ok && a_ok && d_ok;
    endfunction

    function automatic logic [15:0] model_rdata();
        case (reg_sel)
            2'd0: return {8'h00, m_ctrl};
            2'd1: return m_bar;
            2'd2: return m_bdr;
            default: return {15'h0, m_flag};
        endcase
    endfunction

    task automatic tick();
        bit h, nf, nh;
        bit [7:0] nc;
        bit [15:0] nb, nd;
        h = model_hit();
        nc = m_ctrl; nb = m_bar; nd = m_bdr; nf = m_flag; nh = m_hold;
        if (reg_wr) begin
            case (reg_sel)
                2'd0: nc = reg_wdata[7:0];
                2'd1: nb = reg_wdata;
                2'd2: nd = reg_wdata;
                default: if (!reg_wdata[0]) nf = 0;
            endcase
        end
        if (h) nf = 1;
        if (rte_done) nh = !m_ctrl[7];
        else if (insn_done) nh = 0;
        @(posedge clk);
        #1;
        m_ctrl = nc; m_bar = nb; m_bdr = nd; m_flag = nf; m_hold = nh;
        expect_val(cur_req, {15'h0, brk_irq}, {15'h0, m_flag && !(m_hold && !m_ctrl[7])});
        expect_val(cur_req, reg_rdata, model_rdata());
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] v);
        reg_wr = 1; reg_sel = s; reg_wdata = v;
        tick();
        reg_wr = 0;
    endtask

    task automatic set_ctrl(input bit en, input int cyc, input int am, input int dc);
        wr(2'd0, {8'h00, en, 2'(cyc), 3'(am), 2'(dc)});
    endtask

    // t: 0 valid without type, 1 fetch, 2 read, 3 write
    task automatic bus(input int t, input logic [15:0] a, input logic [15:0] d);
        bus_valid = 1; bus_fetch = (t == 1); bus_read = (t == 2); bus_write = (t == 3);
        bus_addr = a; bus_data = d;
        tick();
        bus_valid = 0; bus_fetch = 0; bus_read = 0; bus_write = 0;
    endtask

    task automatic clear_flag();
        wr(2'd3, 16'h0000);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        bus_valid = 0; bus_fetch = 0; bus_read = 0; bus_write = 0;
        bus_addr = 0; bus_data = 0; rte_done = 0; insn_done = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        m_ctrl = 8'h80; m_bar = 0; m_bdr = 0; m_flag = 0; m_hold = 0;

        // R1 reset values
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s); #1;
            expect_val("R1", reg_rdata, (s == 0) ? 16'h0080 : 16'h0000);
        end
        expect_val("R1", {15'h0, brk_irq}, 16'h0);
        tick();

        // R2 read back
        cur_req = "R2";
        wr(2'd0, 16'h007F); reg_sel = 2'd0; #1; expect_val("R2", reg_rdata, 16'h007F);
        wr(2'd1, 16'hA5C3); reg_sel = 2'd1; #1; expect_val("R2", reg_rdata, 16'hA5C3);
        wr(2'd2, 16'h3C96); reg_sel = 2'd2; #1; expect_val("R2", reg_rdata, 16'h3C96);
        wr(2'd0, 16'h0080); reg_sel = 2'd0; #1; expect_val("R2", reg_rdata, 16'h0080);

        // R3 cycle type select
        cur_req = "R3";
        wr(2'd1, 16'h1234);
        for (int c = 0; c < 4; c++) begin
            set_ctrl(1, c, 0, 0);
            for (int t = 0; t < 4; t++) begin
                bit e;
                bus(t, 16'h1234, 16'h0);
                e = (t == 1) ? (c == 0) : (t == 2) ? (c == 1 || c == 3) :
                    (t == 3) ? (c == 2 || c == 3) : 0;
                expect_val("R3", {15'h0, brk_irq}, {15'h0, e});
                clear_flag();
            end
            bus_fetch = 1; bus_read = (c != 0); bus_read = 0; bus_addr = 16'h1234;
            tick(); bus_fetch = 0;
            expect_val("R3", {15'h0, brk_irq}, 16'h0);
        end

        // R4 address masking
        cur_req = "R4";
        for (int am = 0; am < 4; am++) begin
            set_ctrl(1, 0, am, 0);
            for (int k = 0; k < 4; k++) begin
                bus(1, 16'h1234 ^ (16'h0008 << (4 * k)), 16'h0);
                expect_val("R4", {15'h0, brk_irq}, {15'h0, (k < am)});
                clear_flag();
            end
        end

        // R5 reserved mask values
        cur_req = "R5";
        for (int am = 4; am < 8; am++) begin
            set_ctrl(1, 0, am, 0);
            bus(1, 16'h1234, 16'h0);
            expect_val("R5", {15'h0, brk_irq}, 16'h0);
            reg_sel = 2'd3; #1; expect_val("R5", reg_rdata, 16'h0);
        end

        // R6 data lanes
        cur_req = "R6";
        wr(2'd2, 16'hA55A);
        for (int dc = 0; dc < 4; dc++) begin
            set_ctrl(1, 3, 0, dc);
            for (int p = 0; p < 3; p++) begin
                for (int t = 2; t < 4; t++) begin
                    logic [15:0] d;
                    bit e;
                    d = (p == 0) ? 16'hA55A : (p == 1) ? 16'hA5FF : 16'h005A;
                    e = (dc == 0) || (p == 0) || (dc == 1 && p == 2) || (dc == 2 && p == 1);
                    bus(t, 16'h1234, d);
                    expect_val("R6", {15'h0, brk_irq}, {15'h0, e});
                    clear_flag();
                end
            end
        end
        set_ctrl(1, 0, 0, 3);
        bus(1, 16'h1234, 16'h0000);
        expect_val("R6", {15'h0, brk_irq}, 16'h1);
        clear_flag();

        // R7 sticky flag and clear
        cur_req = "R7";
        set_ctrl(1, 1, 0, 0);
        bus(2, 16'h1234, 16'h0);
        expect_val("R7", {15'h0, brk_irq}, 16'h1);
        tick(); tick();
        reg_sel = 2'd3; #1; expect_val("R7", reg_rdata, 16'h1);
        wr(2'd3, 16'h0001);
        expect_val("R7", {15'h0, brk_irq}, 16'h1);
        wr(2'd3, 16'h0000);
        expect_val("R7", {15'h0, brk_irq}, 16'h0);
        bus(2, 16'h1234, 16'h0);
        reg_wr = 1; reg_sel = 2'd3; reg_wdata = 16'h0;
        bus(2, 16'h1234, 16'h0);
        reg_wr = 0;
        expect_val("R7", {15'h0, brk_irq}, 16'h1);
        clear_flag();

        // R8 holdback after return from exception
        cur_req = "R8";
        set_ctrl(0, 1, 0, 0);
        bus(2, 16'h1234, 16'h0);
        expect_val("R8", {15'h0, brk_irq}, 16'h1);
        rte_done = 1; insn_done = 1; tick(); rte_done = 0; insn_done = 0;
        expect_val("R8", {15'h0, brk_irq}, 16'h0);
        tick(); tick();
        expect_val("R8", {15'h0, brk_irq}, 16'h0);
        reg_sel = 2'd3; #1; expect_val("R8", reg_rdata, 16'h1);
        insn_done = 1; tick(); insn_done = 0;
        expect_val("R8", {15'h0, brk_irq}, 16'h1);
        clear_flag();

        // R9 no holdback when enabled
        cur_req = "R9";
        set_ctrl(1, 1, 0, 0);
        bus(2, 16'h1234, 16'h0);
        rte_done = 1; tick(); rte_done = 0;
        expect_val("R9", {15'h0, brk_irq}, 16'h1);
        tick();
        expect_val("R9", {15'h0, brk_irq}, 16'h1);
        clear_flag();

        // random mix against the reference model
        cur_req = "RND R3 R4 R6 R7 R8";
        for (int i = 0; i < 3000; i++) begin
            int t;
            t = $urandom % 4;
            bus_valid = ($urandom % 4) != 0;
            bus_fetch = (t == 1); bus_read = (t == 2); bus_write = (t == 3);
            bus_addr = m_bar ^ (16'($urandom % 16) << (4 * ($urandom % 4)));
            bus_data = m_bdr ^ (($urandom % 2) ? 16'(($urandom % 256) << (8 * ($urandom % 2))) : 16'h0);
            rte_done = ($urandom % 10) == 0;
            insn_done = ($urandom % 3) == 0;
            reg_wr = ($urandom % 8) == 0;
            reg_sel = 2'($urandom % 4);
            if (reg_wr && reg_sel == 2'd0 && rte_done) reg_sel = 2'd3;
            reg_wdata = 16'($urandom);
            if (reg_sel == 2'd1 || reg_sel == 2'd2) reg_wdata = 16'h1234 ^ 16'($urandom % 16);
            tick();
        end
        reg_wr = 0; bus_valid = 0; bus_fetch = 0; bus_read = 0; bus_write = 0;
        rte_done = 0; insn_done = 0;
        tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule